// File: doc/BRIEF.md
# Dual Ring-Oscillator Calibration Counter

This block calibrates a two-line time-to-digital converter against an absolute time base. In calibration, each delay line of the converter runs as a free ring oscillator and drives one ring-clock input. The block opens one measurement window whose length is a programmed number of reference-clock cycles. It counts the rising edges of each ring during that window. Both counters start from the same window-open event and stop at the same window-close event. That common event is the only gating source, so no jitter enters between start and stop. Software divides the window time by each count to get the per-stage delay of each line. Software can request a new calibration at any time to follow voltage and temperature drift.

The window enable is brought into each ring domain by a two-flop synchroniser. Each ring keeps a binary counter that saturates at its maximum value, and it sets a sticky overflow bit when saturation occurs. The counter also publishes a registered Gray-coded copy of its value. After the window closes, the reference side waits a fixed settling period so that every ring domain has seen the close and its Gray copy is quiet. It then samples the synchronised Gray copies, decodes them to binary, registers the results, and pulses a done flag.

Top module: `ringcal_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, both count outputs are zero, both overflow flags are zero and done is low.
- R2: A request is accepted only when calibration mode is 1 and no window or settling period is in progress. A request made with mode 0 is ignored: no done pulse follows, and the outputs keep their previous values.
- R3: An accepted request, sampled at clock edge k, opens a window of L reference cycles, where L is the programmed length. A length of 0 is treated as 1. Done goes high after edge k + L + DRAIN_CYC.
- R4: Done is high for exactly one reference cycle per accepted request.
- R5: Each count output is within 2 of (window duration / ring period) for its own ring, and both rings are measured over the same window.
- R6: A request that arrives while a window or settling period is in progress is ignored. It neither restarts nor extends the window, and it produces no extra done pulse.
- R7: A ring count that would pass 2^CNT_W-1 stays at 2^CNT_W-1 and sets that ring's overflow flag. The other ring is not affected.
- R8: Every accepted request clears both counters and both overflow flags before counting begins.
- R9: The count and overflow outputs change only at the edge that raises done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset (reference domain) |
| cal_mode | input | 1 | 1 = the delay lines run as rings and calibration may start |
| cal_req | input | 1 | Calibration request, sampled on clk |
| win_len | input | WIN_W | Window length in reference cycles (0 is treated as 1) |
| ring_a_clk | input | 1 | Ring oscillator of line A |
| ring_b_clk | input | 1 | Ring oscillator of line B |
| cnt_a | output | CNT_W | Registered edge count of ring A |
| cnt_b | output | CNT_W | Registered edge count of ring B |
| ovf_a | output | 1 | Ring A saturated during the last window |
| ovf_b | output | 1 | Ring B saturated during the last window |
| done | output | 1 | One-cycle pulse: new results are valid |

## Verification
If the window down-counter holds a wrong value, done arrives in the wrong cycle. The bench checks the latency of every done pulse to the exact cycle, so this error shows at the first calibration. A counter that wraps instead of saturating gives a small count with the overflow flag clear after a long window. A missing clear on a new request makes the next short window report a count near the saturation value, which fails the range check of that same calibration. If the reference side accepts requests while it is busy, an extra done pulse appears or done comes late; either shows within one window length.

// File: rtl/ringcal_pkg.sv
package ringcal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WIN   = 2'd1,
    ST_DRAIN = 2'd2
  } cal_state_t;

  function automatic logic [63:0] to_gray(input logic [63:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [63:0] from_gray(input logic [63:0] g, input int unsigned w);
    logic [63:0] b;
    b = '0;
    for (int i = 63; i >= 0; i--) begin
      if (i == 63) b[i] = g[i];
      else         b[i] = b[i+1] ^ g[i];
    end
    if (w < 64) b = b & ((64'd1 << w) - 64'd1);
    return b;
  endfunction

endpackage

// File: rtl/ringcal_sync.sv
module ringcal_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    meta <= d;
    q    <= meta;
  end
endmodule

// File: rtl/ringcal_ring_cnt.sv
module ringcal_ring_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             ring_clk,
  input  logic             rst_ref,
  input  logic             win_en,
  output logic [CNT_W-1:0] cnt_gray,
  output logic             ovf
);
  import ringcal_pkg::*;

  localparam logic [CNT_W-1:0] MAXV = '1;

  logic             rrst;
  logic             en_s;
  logic             en_d;
  logic             start;
  logic [CNT_W-1:0] cnt;
  logic [63:0]      g64;

  ringcal_sync #(.W(1)) u_rst_sync (.clk(ring_clk), .d(rst_ref), .q(rrst));
  ringcal_sync #(.W(1)) u_en_sync  (.clk(ring_clk), .d(win_en),  .q(en_s));

  assign start = en_s & ~en_d;
  assign g64   = to_gray(64'(cnt));

  always_ff @(posedge ring_clk) begin
    if (rrst) begin
      en_d     <= 1'b0;
      cnt      <= '0;
      ovf      <= 1'b0;
      cnt_gray <= '0;
    end else begin
      en_d <= en_s;
      if (start) begin
        cnt <= '0;
        ovf <= 1'b0;
      end else if (en_s) begin
        if (cnt == MAXV) ovf <= 1'b1;
        else             cnt <= cnt + 1'b1;
      end
      cnt_gray <= g64[CNT_W-1:0];
    end
  end

  // R7
  sat_hold_chk: assert property (@(posedge ring_clk) disable iff (rrst)
    (cnt == MAXV && en_s && !start) |=> (cnt == MAXV && ovf));

  // R8
  clear_on_start_chk: assert property (@(posedge ring_clk) disable iff (rrst)
    start |=> (cnt == '0 && !ovf));
endmodule

// File: rtl/ringcal_unit.sv
module ringcal_unit #(
  parameter int CNT_W     = 16,
  parameter int WIN_W     = 16,
  parameter int DRAIN_CYC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cal_mode,
  input  logic             cal_req,
  input  logic [WIN_W-1:0] win_len,
  input  logic             ring_a_clk,
  input  logic             ring_b_clk,
  output logic [CNT_W-1:0] cnt_a,
  output logic [CNT_W-1:0] cnt_b,
  output logic             ovf_a,
  output logic             ovf_b,
  output logic             done
);
  import ringcal_pkg::*;

  localparam int NRING = 2;
  localparam int DRN_W = $clog2(DRAIN_CYC + 1);

  cal_state_t       state;
  logic [WIN_W-1:0] win_cnt;
  logic [DRN_W-1:0] drn_cnt;
  logic             win_en;
  logic             accept;

  logic [NRING-1:0]            ring_clk;
  logic [CNT_W-1:0]            gray_r [NRING];
  logic [CNT_W-1:0]            gray_s [NRING];
  logic [CNT_W-1:0]            bin_s  [NRING];
  logic [NRING-1:0]            ovf_r;
  logic [NRING-1:0]            ovf_s;

  assign ring_clk = {ring_b_clk, ring_a_clk};
  assign accept   = (state == ST_IDLE) && cal_mode && cal_req;

  for (genvar i = 0; i < NRING; i++) begin : g_ring
    logic [63:0] b64;
    ringcal_ring_cnt #(.CNT_W(CNT_W)) u_cnt (
      .ring_clk (ring_clk[i]),
      .rst_ref  (rst),
      .win_en   (win_en),
      .cnt_gray (gray_r[i]),
      .ovf      (ovf_r[i])
    );
    ringcal_sync #(.W(CNT_W)) u_gray_sync (.clk(clk), .d(gray_r[i]), .q(gray_s[i]));
    ringcal_sync #(.W(1))     u_ovf_sync  (.clk(clk), .d(ovf_r[i]),  .q(ovf_s[i]));
    assign b64      = from_gray(64'(gray_s[i]), CNT_W);
    assign bin_s[i] = b64[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      win_cnt <= '0;
      drn_cnt <= '0;
      win_en  <= 1'b0;
      done    <= 1'b0;
      cnt_a   <= '0;
      cnt_b   <= '0;
      ovf_a   <= 1'b0;
      ovf_b   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            win_cnt <= (win_len == '0) ? WIN_W'(1) : win_len;
            win_en  <= 1'b1;
            state   <= ST_WIN;
          end
        end
        ST_WIN: begin
          if (win_cnt == WIN_W'(1)) begin
            win_en  <= 1'b0;
            drn_cnt <= DRN_W'(DRAIN_CYC);
            state   <= ST_DRAIN;
          end else begin
            win_cnt <= win_cnt - 1'b1;
          end
        end
        ST_DRAIN: begin
          if (drn_cnt == DRN_W'(1)) begin
            cnt_a <= bin_s[0];
            cnt_b <= bin_s[1];
            ovf_a <= ovf_s[0];
            ovf_b <= ovf_s[1];
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            drn_cnt <= drn_cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !cal_mode) |=> (state == ST_IDLE && !win_en));

  // R6
  win_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WIN && win_cnt > WIN_W'(1)) |=>
      (state == ST_WIN && win_cnt == $past(win_cnt) - 1'b1));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(cnt_a) && $stable(cnt_b) && $stable(ovf_a) && $stable(ovf_b)));

  // R3
  win_en_state_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN) |=> !win_en);
endmodule

// File: tb/ringcal_unit_bench.sv
`timescale 1ns/1ps
module ringcal_unit_bench;
  localparam int CNT_W = 16;
  localparam int WIN_W = 16;
  localparam int DRAIN = 16;
  localparam real TREF = 20.0;
  localparam real TA   = 7.0;
  localparam real TB   = 13.0;
  localparam longint MAXC = (64'd1 << CNT_W) - 1;

  typedef struct {
    longint req_cyc;
    longint lat;
    longint lo_a, hi_a, lo_b, hi_b;
    bit     ov_a, ov_b;
  } item_t;

  logic clk = 0, rst = 1, ring_a = 0, ring_b = 0;
  logic cal_mode = 0, cal_req = 0;
  logic [WIN_W-1:0] win_len = '0;
  logic [CNT_W-1:0] cnt_a, cnt_b;
  logic ovf_a, ovf_b, done;

  int n_chk = 0, n_fail = 0, n_done = 0;
  longint cyc = 0;
  item_t sbq[$];
  bit finished = 0;

  always #(TREF/2) clk = ~clk;
  always #(TA/2) ring_a = ~ring_a;
  always #(TB/2) ring_b = ~ring_b;
  always @(posedge clk) cyc <= cyc + 1;

  ringcal_unit #(.CNT_W(CNT_W), .WIN_W(WIN_W), .DRAIN_CYC(DRAIN)) u_ringcal_unit (
    .clk(clk), .rst(rst), .cal_mode(cal_mode), .cal_req(cal_req), .win_len(win_len),
    .ring_a_clk(ring_a), .ring_b_clk(ring_b),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .ovf_a(ovf_a), .ovf_b(ovf_b), .done(done));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void rng(input longint l, input real t, output longint lo,
                              output longint hi, output bit ov);
    longint nom;
    nom = longint'($floor(real'(l) * TREF / t));
    lo = (nom > 2) ? nom - 2 : 0;
    hi = nom + 3;
    ov = 0;
    if (hi >= MAXC) begin
      if (lo >= MAXC) begin lo = MAXC; ov = 1; end
      hi = MAXC;
    end
  endfunction

  // driver: issue a request and push its expectation
  task automatic run_cal(input int len);
    item_t it;
    longint l;
    l = (len == 0) ? 1 : len;
    @(negedge clk);
    cal_mode = 1; win_len = WIN_W'(len); cal_req = 1;
    it.req_cyc = cyc + 1;
    it.lat = l + DRAIN;
    rng(l, TA, it.lo_a, it.hi_a, it.ov_a);
    rng(l, TB, it.lo_b, it.hi_b, it.ov_b);
    sbq.push_back(it);
    @(negedge clk);
    cal_req = 0;
  endtask

  task automatic wait_empty();
    while (sbq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: pop and compare on each done
  always @(negedge clk) begin
    if (!rst && done) begin
      n_done++;
      if (sbq.size() == 0) begin
        chk(0, "R2/R6 unexpected done", 1, 0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        chk(cyc - it.req_cyc == it.lat, "R3 done latency", cyc - it.req_cyc, it.lat);
        chk(cnt_a >= it.lo_a && cnt_a <= it.hi_a, "R5/R7 cnt_a", cnt_a, it.lo_a);
        chk(cnt_b >= it.lo_b && cnt_b <= it.hi_b, "R5/R7 cnt_b", cnt_b, it.lo_b);
        chk(ovf_a == it.ov_a, "R7/R8 ovf_a", ovf_a, it.ov_a);
        chk(ovf_b == it.ov_b, "R7/R8 ovf_b", ovf_b, it.ov_b);
      end
    end
  end

  // R4: done never high two sampled cycles in a row
  logic done_q = 0;
  always @(negedge clk) begin
    if (!rst && done && done_q) chk(0, "R4 done width", 2, 1);
    done_q <= done;
  end

  initial begin
    int base_done;
    logic [CNT_W-1:0] ha, hb;
    repeat (6) @(negedge clk);
    // R1 during reset
    chk(cnt_a == 0 && cnt_b == 0, "R1 counts in reset", cnt_a + cnt_b, 0);
    chk(!ovf_a && !ovf_b && !done, "R1 flags in reset", ovf_a + ovf_b + done, 0);
    rst = 0;
    @(negedge clk);
    chk(cnt_a == 0 && cnt_b == 0 && !done, "R1 after release", cnt_a + cnt_b + done, 0);

    // R3 R5 basic window
    run_cal(10);
    wait_empty();

    // R2 mode 0 request ignored, outputs held (R9)
    ha = cnt_a; hb = cnt_b; base_done = n_done;
    @(negedge clk);
    cal_mode = 0; win_len = 16'd50; cal_req = 1;
    @(negedge clk); cal_req = 0;
    repeat (50 + DRAIN + 10) @(negedge clk);
    chk(n_done == base_done, "R2 mode0 no done", n_done - base_done, 0);
    chk(cnt_a == ha && cnt_b == hb, "R2/R9 outputs held", cnt_a, ha);

    // R3 zero length treated as one
    run_cal(0);
    wait_empty();

    // R6 requests during window and drain ignored
    base_done = n_done;
    run_cal(25);
    repeat (5) @(negedge clk);
    cal_req = 1; win_len = 16'd3; @(negedge clk); cal_req = 0;
    repeat (24) @(negedge clk);
    cal_req = 1; @(negedge clk); cal_req = 0;
    wait_empty();
    repeat (40) @(negedge clk);
    chk(n_done - base_done == 1, "R6 single done", n_done - base_done, 1);

    // R7 saturation of ring A only
    run_cal(30000);
    wait_empty();

    // R8 new request clears counters and flags
    run_cal(10);
    wait_empty();

    run_cal(200);
    wait_empty();

    chk(sbq.size() == 0, "R3 all requests completed", sbq.size(), 0);
    finished = 1;
  end

  initial begin
    while (!finished && cyc < 150000) @(negedge clk);
    if (!finished) chk(0, "R3 watchdog", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule